// File: doc/BRIEF.md
# Configurable Logic-Cell Storage Stage

This block is the storage and output stage of one programmable logic cell. A single state bit can act as a D, T, JK or SR flip-flop, or as a flow-through latch. Configuration inputs choose where its data comes from, which clock moves it, whether a clock enable gates that clock, and which asynchronous clear and set sources act on it. The same configuration picks, independently, whether the pin output and the internal feedback carry the stored bit or the combinational sum, and which source drives the output enable.

The block runs on one fast system clock. The cell clocks (three global ones and a product-term clock) are treated as sampled signals: a flip-flop mode captures when the selected cell clock is seen rising between two system edges. In latch mode, a high cell clock makes the data appear at the outputs in the same cycle. The asynchronous clear and set reach the outputs in the same cycle and are also stored, so their effect remains after they are released.

Top module: `mcell_store`

## Requirements
- R1: While `rst_n` is low the stored bit is 0 at once. It stays 0 after release until something writes it.
- R2: With `mode`=0 (D), the stored bit takes the selected data input only when the selected cell clock goes from 0 to 1. Keeping the clock high captures nothing more.
- R3: With `mode`=1 (T), a clock edge inverts the stored bit when the data input is 1 and keeps it when the data input is 0.
- R4: With `mode`=2 (JK), J is the selected data input and K is `pt_b`. On an edge: J=1,K=0 sets the bit, J=0,K=1 clears it, J=K=0 holds it and J=K=1 toggles it.
- R5: With `mode`=3 (SR), S is the selected data input and R is `pt_b`. On an edge: S alone sets the bit, R alone clears it, and both 0 or both 1 hold it.
- R6: With `mode`=4 (latch), the outputs follow the data input in the same cycle while the selected cell clock is high. While it is low they show the last value present before it fell.
- R7: `cksel` 0, 1 and 2 select `gclk[0]`, `gclk[1]` and `gclk[2]`; `cksel`=3 selects `pt_clk`. Edges on the clocks that are not selected have no effect.
- R8: With `ce_en`=1 and a global clock selected, edges arriving while `pt_ce` is 0 are ignored. With `pt_clk` selected, `pt_ce` has no effect.
- R9: `arsel` selects the asynchronous clear: 0 none, 1 `gclr`, 2 `pt_ar`, 3 either of them. `ap_en`=1 lets `pt_ap` set the bit asynchronously. Clear wins over set. Both act in the same cycle without a clock edge, and the result stays stored after release.
- R10: `dsel` selects the data input: 0 `xor_in`, 1 `pt_data`, 2 `pin_in`.
- R11: `osel`=1 drives the stored bit on `pin_out` and `osel`=0 drives `xor_in` there. `fbsel` makes the same choice for `fb_out`, independently of `osel`.
- R12: `oesel` selects `pin_oe`: 0 always on, 1 always off, 2 `oe_pin[0]`, 3 `oe_pin[1]`, 4 `pt_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all cell inputs |
| rst_n | input | 1 | Active-low power-up reset, clears the state |
| mode | input | 3 | Storage mode: 0 D, 1 T, 2 JK, 3 SR, 4 latch |
| dsel | input | 2 | Data source select |
| cksel | input | 2 | Cell clock select (3 = product-term clock) |
| ce_en | input | 1 | Enables clock gating by `pt_ce` on global clocks |
| arsel | input | 2 | Asynchronous clear source select |
| ap_en | input | 1 | Enables asynchronous set by `pt_ap` |
| osel | input | 1 | Pin output: 1 stored, 0 combinational |
| fbsel | input | 1 | Feedback: 1 stored, 0 combinational |
| oesel | input | 3 | Output-enable source select |
| xor_in | input | 1 | Combinational sum from the XOR stage |
| pt_data | input | 1 | Separate product-term data |
| pin_in | input | 1 | Data from the pin |
| pt_b | input | 1 | Second input: K in JK mode, R in SR mode |
| gclk | input | 3 | Global cell clocks |
| pt_clk | input | 1 | Product-term cell clock |
| pt_ce | input | 1 | Product-term clock enable |
| gclr | input | 1 | Global clear |
| pt_ar | input | 1 | Product-term clear |
| pt_ap | input | 1 | Product-term set |
| oe_pin | input | 2 | Dedicated output-enable inputs |
| pt_oe | input | 1 | Product-term output enable |
| pin_out | output | 1 | Value driven toward the pad |
| pin_oe | output | 1 | Output enable toward the pad |
| fb_out | output | 1 | Buried feedback into the array |

## Verification
A vector table walks the four edge modes through every input pair, starting from known states. A wrong JK toggle or a wrong SR hold therefore shows up as a wrong bit after a particular edge. The tests hold the clock high while the data changes, which separates edge capture from level capture. Edges are applied on clocks that are not selected and while the enable is low, which shows which source and which gate the design really uses. Latch tests change the data on both clock levels, and the asynchronous tests check the outputs before any clock edge and after release, so the order of clear over set and the stored result can both be seen.

// File: rtl/mcell_store.sv
module mcell_store #(
  parameter int N_GCLK = 3,
  parameter int N_OE   = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [2:0]                  mode,
  input  logic [1:0]                  dsel,
  input  logic [$clog2(N_GCLK+1)-1:0] cksel,
  input  logic                        ce_en,
  input  logic [1:0]                  arsel,
  input  logic                        ap_en,
  input  logic                        osel,
  input  logic                        fbsel,
  input  logic [2:0]                  oesel,
  input  logic                        xor_in,
  input  logic                        pt_data,
  input  logic                        pin_in,
  input  logic                        pt_b,
  input  logic [N_GCLK-1:0]           gclk,
  input  logic                        pt_clk,
  input  logic                        pt_ce,
  input  logic                        gclr,
  input  logic                        pt_ar,
  input  logic                        pt_ap,
  input  logic [N_OE-1:0]             oe_pin,
  input  logic                        pt_oe,
  output logic                        pin_out,
  output logic                        pin_oe,
  output logic                        fb_out
);
  localparam int CKW = $clog2(N_GCLK+1);
  localparam logic [2:0] M_D = 3'd0, M_T = 3'd1, M_JK = 3'd2, M_SR = 3'd3, M_LAT = 3'd4;

  logic q_reg, ck_prev, ck_now, din, nxt, q_eff;

  wire use_pt  = (cksel >= CKW'(N_GCLK));
  wire ck_ok   = use_pt | ~ce_en | pt_ce;
  wire is_lat  = (mode == M_LAT);
  wire rise    = ck_now & ~ck_prev & ck_ok & ~is_lat;
  wire open_l  = is_lat & ck_now & ck_ok;
  wire ar_now  = (arsel[0] & gclr) | (arsel[1] & pt_ar);
  wire ap_now  = ap_en & pt_ap;

  always_comb begin
    ck_now = pt_clk;
    for (int i = 0; i < N_GCLK; i++)
      if (cksel == CKW'(i)) ck_now = gclk[i];
  end

  always_comb begin
    case (dsel)
      2'd1:    din = pt_data;
      2'd2:    din = pin_in;
      default: din = xor_in;
    endcase
  end

  always_comb begin
    case (mode)
      M_D:  nxt = din;
      M_T:  nxt = q_reg ^ din;
      M_JK: nxt = (din & pt_b) ? ~q_reg : din ? 1'b1 : pt_b ? 1'b0 : q_reg;
      M_SR: nxt = (din & pt_b) ? q_reg : din ? 1'b1 : pt_b ? 1'b0 : q_reg;
      default: nxt = q_reg;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_reg   <= 1'b0;
      ck_prev <= 1'b0;
    end else begin
      ck_prev <= ck_now;
      if (ar_now)      q_reg <= 1'b0;
      else if (ap_now) q_reg <= 1'b1;
      else if (open_l) q_reg <= din;
      else if (rise)   q_reg <= nxt;
    end
  end

  assign q_eff   = ar_now ? 1'b0 : ap_now ? 1'b1 : open_l ? din : q_reg;
  assign pin_out = osel  ? q_eff : xor_in;
  assign fb_out  = fbsel ? q_eff : xor_in;

  always_comb begin
    case (oesel)
      3'd0:    pin_oe = 1'b1;
      3'd2:    pin_oe = oe_pin[0];
      3'd3:    pin_oe = oe_pin[N_OE-1];
      3'd4:    pin_oe = pt_oe;
      default: pin_oe = 1'b0;
    endcase
  end

  assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ar_now |=> !q_reg);
  assert_set_stored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ap_now && !ar_now) |=> q_reg);
  assert_gated_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!use_pt && ce_en && !pt_ce && !is_lat && !ar_now && !ap_now) |=> $stable(q_reg));
  assert_d_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_D && rise && !ar_now && !ap_now) |=> (q_reg == $past(din)));
  assert_t_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_T && rise && din && !ar_now && !ap_now) |=> (q_reg != $past(q_reg)));
  assert_sr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_SR && rise && din && pt_b && !ar_now && !ap_now) |=> $stable(q_reg));
  assert_no_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ck_now && !ar_now && !ap_now) |=> $stable(q_reg));
endmodule

// File: tb/mcell_store_tb.sv
module mcell_store_tb;
  logic clk = 0, rst_n = 0;
  logic [2:0] mode = 0, oesel = 0;
  logic [1:0] dsel = 0, cksel = 0, arsel = 0, oe_pin = 0;
  logic ce_en = 0, ap_en = 0, osel = 1, fbsel = 1;
  logic xor_in = 0, pt_data = 0, pin_in = 0, pt_b = 0;
  logic [2:0] gclk = 0;
  logic pt_clk = 0, pt_ce = 0, gclr = 0, pt_ar = 0, pt_ap = 0, pt_oe = 0;
  logic pin_out, pin_oe, fb_out;
  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mcell_store u_dut (.clk, .rst_n, .mode, .dsel, .cksel, .ce_en, .arsel, .ap_en,
    .osel, .fbsel, .oesel, .xor_in, .pt_data, .pin_in, .pt_b, .gclk, .pt_clk,
    .pt_ce, .gclr, .pt_ar, .pt_ap, .oe_pin, .pt_oe, .pin_out, .pin_oe, .fb_out);

  // {mode, a, b, expected stored bit}, applied in order from a cleared state
  localparam logic [5:0] VEC [15] = '{
    {3'd0,1'b1,1'b0,1'b1}, {3'd0,1'b0,1'b0,1'b0},
    {3'd1,1'b1,1'b0,1'b1}, {3'd1,1'b0,1'b0,1'b1}, {3'd1,1'b1,1'b0,1'b0},
    {3'd2,1'b1,1'b0,1'b1}, {3'd2,1'b1,1'b1,1'b0}, {3'd2,1'b1,1'b1,1'b1},
    {3'd2,1'b0,1'b1,1'b0}, {3'd2,1'b0,1'b0,1'b0},
    {3'd3,1'b1,1'b0,1'b1}, {3'd3,1'b1,1'b1,1'b1}, {3'd3,1'b0,1'b1,1'b0},
    {3'd3,1'b1,1'b1,1'b0}, {3'd3,1'b0,1'b0,1'b0}};

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic pulse(input int idx);
    @(negedge clk);
    if (idx == 3) pt_clk = 1; else gclk[idx] = 1;
    @(negedge clk);
    if (idx == 3) pt_clk = 0; else gclk[idx] = 0;
    @(negedge clk);
    #1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000 && !done) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #3 chk("R1 reset", pin_out, 1'b0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1 chk("R1 after release", fb_out, 1'b0);

    for (int i = 0; i < 15; i++) begin
      mode = VEC[i][5:3]; xor_in = VEC[i][2]; pt_b = VEC[i][1];
      pulse(0);
      chk(mode == 0 ? "R2 D" : mode == 1 ? "R3 T" : mode == 2 ? "R4 JK" : "R5 SR",
          pin_out, VEC[i][0]);
    end

    // R2: level high holds, no second capture
    mode = 0; xor_in = 1;
    @(negedge clk) gclk[0] = 1;
    @(negedge clk) xor_in = 0;
    repeat (2) @(negedge clk);
    #1 chk("R2 held high", pin_out, 1'b1);
    @(negedge clk) gclk[0] = 0;

    // R6: latch
    xor_in = 0; pulse(0);
    mode = 4; xor_in = 1;
    #1 chk("R6 closed", pin_out, 1'b0);
    @(negedge clk) gclk[0] = 1;
    #1 chk("R6 open follows 1", pin_out, 1'b1);
    @(negedge clk) xor_in = 0;
    #1 chk("R6 open follows 0", pin_out, 1'b0);
    @(negedge clk) xor_in = 1;
    @(negedge clk) gclk[0] = 0;
    #1 xor_in = 0;
    #1 chk("R6 holds", pin_out, 1'b1);
    @(negedge clk);
    #1 chk("R6 holds later", fb_out, 1'b1);

    // R9: asynchronous clear and set
    mode = 0;
    @(negedge clk) gclr = 1;
    #1 chk("R9 clear off", pin_out, 1'b1);
    arsel = 1;
    #1 chk("R9 gclr clears", pin_out, 1'b0);
    @(negedge clk) gclr = 0;
    @(negedge clk);
    #1 chk("R9 clear stored", pin_out, 1'b0);
    ap_en = 1; pt_ap = 1;
    #1 chk("R9 set", pin_out, 1'b1);
    arsel = 2; pt_ar = 1;
    #1 chk("R9 clear wins", pin_out, 1'b0);
    @(negedge clk) begin pt_ar = 0; pt_ap = 0; end
    @(negedge clk);
    #1 chk("R9 stored after both", pin_out, 1'b0);
    pt_ap = 1;
    @(negedge clk) pt_ap = 0;
    arsel = 3; gclr = 1;
    #1 chk("R9 OR via gclr", pin_out, 1'b0);
    @(negedge clk) begin gclr = 0; pt_ap = 1; end
    @(negedge clk) pt_ap = 0;
    pt_ar = 1;
    #1 chk("R9 OR via pt_ar", pin_out, 1'b0);
    @(negedge clk) pt_ar = 0;
    arsel = 0; ap_en = 0;

    // R10: data sources
    dsel = 1; pt_data = 1; xor_in = 0; pin_in = 0;
    pulse(0); chk("R10 pt_data", pin_out, 1'b1);
    dsel = 2; pt_data = 1; pin_in = 0;
    pulse(0); chk("R10 pin_in 0", pin_out, 1'b0);
    pin_in = 1;
    pulse(0); chk("R10 pin_in 1", pin_out, 1'b1);
    dsel = 0;

    // R11: output and feedback selection
    xor_in = 0; osel = 0; fbsel = 1;
    #1 chk("R11 pin comb", pin_out, 1'b0);
    chk("R11 fb reg", fb_out, 1'b1);
    osel = 1; fbsel = 0;
    #1 chk("R11 pin reg", pin_out, 1'b1);
    chk("R11 fb comb", fb_out, 1'b0);
    fbsel = 1;

    // R7: clock selection (stored bit is 1, data 0)
    cksel = 2;
    pulse(0); chk("R7 gclk0 ignored", pin_out, 1'b1);
    pulse(2); chk("R7 gclk2 used", pin_out, 1'b0);
    cksel = 3; xor_in = 1;
    pulse(1); chk("R7 gclk1 ignored", pin_out, 1'b0);
    pulse(3); chk("R7 pt_clk used", pin_out, 1'b1);

    // R8: clock enable
    cksel = 0; ce_en = 1; pt_ce = 0; xor_in = 0;
    pulse(0); chk("R8 gated", pin_out, 1'b1);
    pt_ce = 1;
    pulse(0); chk("R8 enabled", pin_out, 1'b0);
    cksel = 3; pt_ce = 0; xor_in = 1;
    pulse(3); chk("R8 no gate on pt_clk", pin_out, 1'b1);
    ce_en = 0; cksel = 0;

    // R12: output enable
    oe_pin = 2'b01; pt_oe = 0;
    oesel = 0; #1 chk("R12 on", pin_oe, 1'b1);
    oesel = 1; #1 chk("R12 off", pin_oe, 1'b0);
    oesel = 2; #1 chk("R12 oe0", pin_oe, 1'b1);
    oesel = 3; #1 chk("R12 oe1", pin_oe, 1'b0);
    oe_pin = 2'b10; #1 chk("R12 oe1 high", pin_oe, 1'b1);
    oesel = 4; #1 chk("R12 pt_oe low", pin_oe, 1'b0);
    pt_oe = 1; #1 chk("R12 pt_oe high", pin_oe, 1'b1);

    // R1: reset mid-run (stored bit is 1)
    @(negedge clk) rst_n = 0;
    #1 chk("R1 mid-run", pin_out, 1'b0);
    @(negedge clk) rst_n = 1;
    @(negedge clk);
    #1 chk("R1 stays cleared", fb_out, 1'b0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule